// File: doc/BRIEF.md
# Single-Slope RC Converter Sequencer

This block controls an analog-to-digital converter built from one resistor, one capacitor and a comparator, all outside the chip. To measure a voltage, the block drives a charge pin high. The capacitor then rises through the resistor while an 8-bit timing counter counts elapsed time. The counter starts at a non-zero offset and advances once every eight clocks. The conversion ends when the comparator first rises, meaning the capacitor has passed the unknown input. It also ends if the counter wraps past its top value, which means the input is above the usable range. When the conversion ends, the charge pin drops so the capacitor discharges, and a 6-bit result is presented with a done flag.

A result from a comparator trip is the captured count minus the offset, minus one more count. The extra count removes the latency of the input synchronizer. A wrap instead produces a saturated full-scale code and an over-range flag. The capacitor must be empty before it is charged again. For that reason, a guard interval given in clock cycles follows every conversion, and the block refuses new starts until the interval has run out. Software or a sequencer pulses `start`, waits for `done`, and then reads `result` and `over_range`.

Top module: `rc_slope_adc`

## Requirements
- R1: After reset, `charge`, `busy`, `done` and `over_range` are 0 and `result` is 0. A start in the first cycle after reset is accepted, because the guard interval counts as already expired.
- R2: A start seen at a clock edge while `busy` is 0 is accepted at that edge. From that edge on, `charge` is 1, `busy` is 1 and `done` is 0.
- R3: The timing counter holds 192 after an accepted start and increments once every 8 clocks. The comparator input passes through two synchronizer flops and a rising-edge detector. A 0-to-1 change applied just after the k-th edge following the accepting edge therefore ends the conversion at edge k+3.
- R4: On a comparator end, `result` is the count held just before the ending edge minus 193. It is clamped to 0 when that count is still 192. Such a result is at most 62 and leaves `over_range` at 0.
- R5: With no comparator rise, the conversion ends at the 512th edge after the accepting edge, with `over_range` = 1 and `result` = 63.
- R6: If a comparator end and a counter wrap fall on the same edge, the comparator wins: `result` = 62 and `over_range` = 0.
- R7: At the ending edge, `charge` goes to 0 and `done` goes to 1.
- R8: `busy` stays 1 for exactly GUARD_CYCLES edges after the ending edge. A start during that interval is ignored.
- R9: A start while a conversion is running is ignored. It does not restart the counter or change the end time.
- R10: A comparator rise outside a conversion has no effect. A comparator input that is already high when a conversion starts gives no edge, so that conversion runs to the counter wrap.
- R11: `result` and `over_range` stay constant, and `done` stays 1, from the ending edge until the next accepted start.
- R12: An accepted start clears `over_range` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled at each edge |
| cmp_in | input | 1 | Asynchronous comparator output, high when the capacitor is above the input |
| charge | output | 1 | High to charge the capacitor, low to discharge it |
| busy | output | 1 | Conversion running or discharge guard active |
| done | output | 1 | Last conversion complete |
| over_range | output | 1 | Last conversion ended by counter wrap |
| result | output | 6 | Converted code |

## Verification
The design state is small: a running bit, a prescaler, a timing counter, a guard counter and a synchronizer. Each of them shows up at the ports within one conversion. A wrong prescaler or a wrong preload moves both the ending edge and the code, and the ending edge is checked exactly for every comparator delay in a near-complete sweep. A guard counter that loads or decrements wrongly changes how many cycles `busy` stays high, which is checked after every conversion. A start that slips through during the guard or during a conversion would clear `done` or shift the end edge at once. A missing synchronizer stage shifts every comparator-terminated result by one count wherever the delay crosses an 8-cycle boundary.

// File: rtl/rc_slope_adc.sv
module rc_slope_adc #(
  parameter int CLK_DIV      = 8,
  parameter int CNT_W        = 8,
  parameter int RES_W        = 6,
  parameter int GUARD_CYCLES = 25000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_in,
  output logic             charge,
  output logic             busy,
  output logic             done,
  output logic             over_range,
  output logic [RES_W-1:0] result
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int GRD_W = $clog2(GUARD_CYCLES + 1);
  localparam logic [CNT_W-1:0] PRELOAD  = CNT_W'((2 ** CNT_W) - (2 ** RES_W));
  localparam logic [CNT_W-1:0] CNT_TOP  = '1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [RES_W-1:0] RES_FULL = '1;
  localparam logic [GRD_W-1:0] GRD_LOAD = GRD_W'(GUARD_CYCLES);

  logic [2:0]       cmp_sync;
  logic             running;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] cnt;
  logic [GRD_W-1:0] guard;

  logic             rise, tick, wrap, trip, finish, accept;
  logic [CNT_W-1:0] span;
  logic [RES_W-1:0] code;

  assign rise   = cmp_sync[1] & ~cmp_sync[2];
  assign tick   = running && (div == DIV_LAST);
  assign wrap   = tick && (cnt == CNT_TOP);
  assign trip   = running && rise;
  assign finish = trip || wrap;
  assign busy   = running || (guard != '0);
  assign accept = start && !busy;
  assign span   = cnt - PRELOAD;
  assign code   = (span == '0) ? '0 : RES_W'(span - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_sync <= '0;
    else        cmp_sync <= {cmp_sync[1:0], cmp_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      charge     <= 1'b0;
      done       <= 1'b0;
      over_range <= 1'b0;
      result     <= '0;
      div        <= '0;
      cnt        <= '0;
      guard      <= '0;
    end else if (accept) begin
      done       <= 1'b0;
      over_range <= 1'b0;
      cnt        <= PRELOAD;
      div        <= '0;
      running    <= 1'b1;
      charge     <= 1'b1;
    end else if (finish) begin
      running    <= 1'b0;
      charge     <= 1'b0;
      done       <= 1'b1;
      guard      <= GRD_LOAD;
      over_range <= !trip;
      result     <= trip ? code : RES_FULL;
    end else begin
      if (running) begin
        div <= tick ? '0 : div + 1'b1;
        if (tick) cnt <= cnt + 1'b1;
      end
      if (guard != '0) guard <= guard - 1'b1;
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (charge && busy && !done));

  // R7
  end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !charge);

  // R5
  over_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_range |-> (result == RES_FULL));

  // R4
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !over_range) |-> (result != RES_FULL));

  // R8
  guard_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !charge) |=> !charge);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(start && !busy)) |=> (done && $stable(result) && $stable(over_range)));

  // R12
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !over_range);

endmodule

// File: tb/tb_rc_slope_adc.sv
module tb_rc_slope_adc;
  localparam int G = 37;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp_in = 1'b0;
  logic charge, busy, done, over_range;
  logic [5:0] result;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  rc_slope_adc #(.GUARD_CYCLES(G)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
    .charge(charge), .busy(busy), .done(done),
    .over_range(over_range), .result(result)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // a: comparator rises after edge a (-1 = never); inj: start pulse at edge index (-1 none)
  task automatic conv(input int a, input int inj, input bit poke);
    int e, k, exp_m, exp_r;
    bit exp_o;
    logic [5:0] r0;
    logic o0;
    k = 0;
    while (busy && k < 5000) begin @(posedge clk); k++; @(negedge clk); end
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    e = 0;
    chk("R2 charge", charge === 1'b1, charge, 1);
    chk("R2 busy/done", busy === 1'b1 && done === 1'b0, done, 0);
    chk("R12 over_range cleared", over_range === 1'b0, over_range, 0);
    while (!done && e < 2000) begin
      if (e == a) cmp_in = 1'b1;
      start = (e == inj);
      @(posedge clk); e++; @(negedge clk);
    end
    start = 1'b0;
    if (a >= 0 && a + 3 <= 512) begin
      exp_m = a + 3; exp_o = 1'b0;
      exp_r = (a + 2) / 8 - 1;
      if (exp_r < 0) exp_r = 0;
    end else begin
      exp_m = 512; exp_o = 1'b1; exp_r = 63;
    end
    chk(a < 0 ? "R10 end edge" : (inj >= 0 ? "R9 end edge" : "R3 end edge"), e == exp_m, e, exp_m);
    chk(exp_o ? "R5 result" : (a == 509 ? "R6 result" : "R4 result"), result == 6'(exp_r), result, exp_r);
    chk(exp_o ? "R5 over_range" : "R4 over_range", over_range === exp_o, over_range, exp_o);
    chk("R7 charge low, done high", charge === 1'b0 && done === 1'b1, charge, 0);
    r0 = result; o0 = over_range;
    cmp_in = 1'b0;
    k = 0;
    while (busy && k < 5000) begin
      start = poke && (k == 5);
      if (poke && k >= 10) cmp_in = 1'b1;
      @(posedge clk); k++; @(negedge clk);
    end
    start = 1'b0;
    chk("R8 guard length", k == G, k, G);
    chk("R11 result held", result == r0 && over_range == o0 && done === 1'b1, result, r0);
    if (poke) chk("R10 R8 ignored during guard", done === 1'b1 && charge === 1'b0, done, 1);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle outputs", {charge, busy, done, over_range} == 4'b0, {charge, busy, done, over_range}, 0);
    chk("R1 result zero", result == 6'd0, result, 0);

    for (int a = 0; a <= 515; a += (a < 500) ? 3 : 1) conv(a, -1, 1'b0);
    conv(509, -1, 1'b0);
    conv(1, -1, 1'b0);
    conv(100, 20, 1'b0);
    conv(40, 2, 1'b0);
    conv(60, -1, 1'b1);
    conv(-1, -1, 1'b0);
    cmp_in = 1'b0;
    repeat (4) @(negedge clk);
    conv(200, -1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule